// File: doc/BRIEF.md
# 8-bit ALU with condition codes

This block is the purely combinational arithmetic and logic stage of a small accumulator machine. It takes two byte operands, a carry input, a five-bit operation code and the present condition-code byte. It returns a result byte together with the next condition-code byte. Operand fetch, register write-back and memory access are done by the surrounding datapath. This block computes only the result and the flags.

Every operation has its own flag rule. Each flag is either computed from the operation, forced to a constant, or copied from the incoming byte. The operations are binary arithmetic (add, add with carry, subtract, subtract with borrow, compare), bitwise logic (AND, OR, XOR, bit test, load/transfer), unary operations on the first operand (complement, negate, increment, decrement, clear, test, five shift or rotate forms) and decimal adjust after a BCD addition. The surrounding datapath writes back `result` only for operations that change a register. For compare, bit test and test, `result` repeats the first operand unchanged.

Top module: `alu8_core`

## Requirements
- R1: Condition-code layout, in both `cc_in` and `cc_out`: bit0 C, bit1 V, bit2 Z, bit3 N, bit4 I, bit5 H, bits 7:6. On every operation, bits 7:6 of `cc_out` read 1 and bit4 equals bit4 of `cc_in`. For every defined operation, N is bit 7 of the computed value and Z is set when the computed value is zero.
- R2: Code 0 adds, `result = opa + opb`. Code 1 adds with carry, `result = opa + opb + carry_in`. For both, C is the carry out of bit 7, H is the carry out of bit 3, and V is set when the two operands have the same sign and the result sign differs from it.
- R3: Code 2 subtracts, `opa - opb`. Code 3 subtracts with borrow, `opa - opb - carry_in`. Code 4 compares: it computes `opa - opb` for the flags only, and `result = opa`. For all three, C is the unsigned borrow and V is set when the operand signs differ and the result sign differs from `opa`.
- R4: Codes 5 (AND), 6 (OR), 7 (XOR), 8 (bit test: AND for the flags only, `result = opa`) and 21 (load/transfer: `result = opb`) clear V and leave C unchanged.
- R5: Code 9 complements: `result = 0xFF - opa`. It forces C=1 and V=0.
- R6: Code 10 negates: `result = 0 - opa`. C is set when `opa` is nonzero. V is set when `opa` is 0x80.
- R7: Code 11 increments `opa` and code 12 decrements it. V is set when the input is 0x7F (increment) or 0x80 (decrement). C is unchanged.
- R8: Code 13 clears: `result = 0` and N=0, Z=1, V=0, C=0. Code 14 tests: `result = opa`, and it clears V and C.
- R9: Code 15 shifts left, with bit 7 going to C and 0 going into bit 0. Code 16 shifts right arithmetically, keeping bit 7, with bit 0 going to C. Code 17 shifts right logically, with 0 going into bit 7 and bit 0 going to C. For these shifts V = N XOR C after the shift.
- R10: Code 18 rotates left: `carry_in` goes into bit 0 and bit 7 goes to C. Code 19 rotates right: `carry_in` goes into bit 7 and bit 0 goes to C. For both rotates V = N XOR C.
- R11: Code 20 decimal-adjusts `opa` using H from `cc_in` and `carry_in` as the previous carry. It adds 0x06 when H=1 or the low nibble exceeds 9. It adds 0x60 when the carry is set, the high nibble exceeds 9, or the high nibble is 9 and the low nibble exceeds 9. C is the previous carry OR the high correction.
- R12: H in `cc_out` equals H in `cc_in` for every code except 0 and 1. Decimal adjust leaves V unchanged.
- R13: Codes 22 to 31 give `result = opa` and `cc_out = cc_in | 0xC0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 8 | First operand (accumulator side) |
| opb | input | 8 | Second operand |
| carry_in | input | 1 | Carry or borrow for add with carry, subtract with borrow, rotates and decimal adjust |
| op_sel | input | 5 | Operation code |
| cc_in | input | 8 | Present condition-code byte |
| result | output | 8 | Result byte |
| cc_out | output | 8 | Next condition-code byte |

## Verification
There are no register stages between the ports, so both `result` and `cc_out` are due in the same cycle as the stimulus, zero clock edges later. The bench changes all inputs at once, waits one nanosecond for the logic to settle, and only then compares the outputs against values it computes with integer arithmetic. It then moves to the next vector. The sweep covers all 32 codes, every `opa` value, a stepped set of `opb` values, both carry inputs and both states of the incoming H flag.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W   = 8;
    localparam int NIB_W    = DATA_W / 2;
    localparam int OP_W     = 5;
    localparam int FLAG_CNT = 5;
    localparam int CC_W     = 8;
    localparam int BCD_MAX  = 9;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,
        OP_AND  = 5'd5,
        OP_ORA  = 5'd6,
        OP_EOR  = 5'd7,
        OP_BIT  = 5'd8,
        OP_COM  = 5'd9,
        OP_NEG  = 5'd10,
        OP_INC  = 5'd11,
        OP_DEC  = 5'd12,
        OP_CLR  = 5'd13,
        OP_TST  = 5'd14,
        OP_ASL  = 5'd15,
        OP_ASR  = 5'd16,
        OP_LSR  = 5'd17,
        OP_ROL  = 5'd18,
        OP_ROR  = 5'd19,
        OP_DAA  = 5'd20,
        OP_PASS = 5'd21
    } alu_op_e;

    // Flag order inside a flags_t: h (msb) .. c (lsb)
    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    // What each execution unit hands to the merge stage
    typedef struct packed {
        word_t  y;
        flags_t val;
        flags_t wen;
    } unit_res_t;

    typedef enum logic [2:0] {
        U_ARITH,
        U_LOGIC,
        U_SHIFT,
        U_DECADJ,
        U_NONE
    } unit_e;

    typedef struct packed {
        word_t y;
        logic  c;
        logic  h;
        logic  v;
    } addsub_t;

    // One adder serves add and subtract; subtract inverts the second
    // operand and the carry, and reports borrow as the inverted carry.
    function automatic addsub_t f_addsub(word_t x, word_t w, logic cin, logic sub);
        word_t          wo;
        logic [DATA_W:0] full;
        logic [NIB_W:0]  low;
        logic            ci;
        addsub_t         r;
        wo   = sub ? ~w : w;
        ci   = cin ^ sub;
        full = {1'b0, x} + {1'b0, wo} + {{DATA_W{1'b0}}, ci};
        low  = {1'b0, x[NIB_W-1:0]} + {1'b0, wo[NIB_W-1:0]} + {{NIB_W{1'b0}}, ci};
        r.y  = full[DATA_W-1:0];
        r.c  = full[DATA_W] ^ sub;
        r.h  = low[NIB_W];
        r.v  = (x[DATA_W-1] == wo[DATA_W-1]) && (r.y[DATA_W-1] != x[DATA_W-1]);
        return r;
    endfunction

    function automatic unit_e f_unit(alu_op_e op);
        unit_e u;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP,
            OP_NEG, OP_INC, OP_DEC:                   u = U_ARITH;
            OP_AND, OP_ORA, OP_EOR, OP_BIT, OP_PASS,
            OP_COM, OP_CLR, OP_TST:                   u = U_LOGIC;
            OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR:   u = U_SHIFT;
            OP_DAA:                                   u = U_DECADJ;
            default:                                  u = U_NONE;
        endcase
        return u;
    endfunction

    function automatic flags_t f_nz(word_t w);
        flags_t f;
        f   = '0;
        f.n = w[DATA_W-1];
        f.z = (w == '0);
        return f;
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
(
    input  alu_op_e   op,
    input  word_t     a,
    input  word_t     b,
    input  logic      cin,
    output unit_res_t res
);

    addsub_t s;
    word_t   lhs;
    word_t   rhs;
    logic    c_used;
    logic    do_sub;

    // Operand steering for the shared adder
    always_comb begin
        lhs    = a;
        rhs    = b;
        c_used = 1'b0;
        do_sub = 1'b0;
        case (op)
            OP_ADC:          c_used = cin;
            OP_SUB, OP_CMP:  do_sub = 1'b1;
            OP_SBC: begin
                do_sub = 1'b1;
                c_used = cin;
            end
            OP_NEG: begin
                lhs    = '0;
                rhs    = a;
                do_sub = 1'b1;
            end
            OP_INC: begin
                rhs    = '0;
                c_used = 1'b1;
            end
            OP_DEC: begin
                rhs    = '0;
                do_sub = 1'b1;
                c_used = 1'b1;
            end
            default: ;
        endcase
        s = f_addsub(lhs, rhs, c_used, do_sub);
    end

    always_comb begin
        res.val   = f_nz(s.y);
        res.val.h = s.h;
        res.val.v = s.v;
        res.val.c = s.c;
        res.y     = s.y;
        res.wen   = '0;
        case (op)
            OP_ADD, OP_ADC:
                res.wen = '{h: 1'b1, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
            OP_SUB, OP_SBC, OP_NEG:
                res.wen = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
            OP_CMP: begin
                res.wen = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
                res.y   = a;
            end
            OP_INC, OP_DEC:
                res.wen = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b0};
            default:
                res.y = a;
        endcase
    end

    // R2: nine-bit sum checked against plain integer addition
    always_comb begin
        if (op == OP_ADD) begin
            assert_add_sum_R2: assert ({res.val.c, res.y} == ({1'b0, a} + {1'b0, b}))
                else $error("add sum/carry mismatch");
        end
    end

    // R3: borrow equals an unsigned magnitude compare
    always_comb begin
        if (op == OP_SUB) begin
            assert_sub_borrow_R3: assert (res.val.c == (a < b))
                else $error("subtract borrow mismatch");
        end
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
(
    input  alu_op_e   op,
    input  word_t     a,
    input  word_t     b,
    output unit_res_t res
);

    word_t fv;

    always_comb begin
        fv    = a;
        res.y = a;
        case (op)
            OP_AND:  fv = a & b;
            OP_ORA:  fv = a | b;
            OP_EOR:  fv = a ^ b;
            OP_BIT:  fv = a & b;
            OP_PASS: fv = b;
            OP_COM:  fv = ~a;
            OP_CLR:  fv = '0;
            OP_TST:  fv = a;
            default: fv = a;
        endcase
        if (op != OP_BIT && op != OP_TST)
            res.y = fv;

        res.val   = f_nz(fv);
        res.val.v = 1'b0;
        res.val.c = (op == OP_COM);
        case (op)
            OP_AND, OP_ORA, OP_EOR, OP_BIT, OP_PASS:
                res.wen = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b0};
            OP_COM, OP_CLR, OP_TST:
                res.wen = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
            default:
                res.wen = '0;
        endcase
    end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
(
    input  alu_op_e   op,
    input  word_t     a,
    input  logic      cin,
    output unit_res_t res
);

    localparam int MSB = DATA_W - 1;

    word_t sv;
    logic  co;
    logic  fill;
    logic  left;

    // Direction and fill bit select; carry is the bit shifted out
    always_comb begin
        left = (op == OP_ASL) || (op == OP_ROL);
        case (op)
            OP_ASL:  fill = 1'b0;
            OP_LSR:  fill = 1'b0;
            OP_ASR:  fill = a[MSB];
            OP_ROL:  fill = cin;
            OP_ROR:  fill = cin;
            default: fill = 1'b0;
        endcase
        if (left) begin
            sv = {a[MSB-1:0], fill};
            co = a[MSB];
        end else begin
            sv = {fill, a[MSB:1]};
            co = a[0];
        end
    end

    always_comb begin
        res.val   = f_nz(sv);
        res.val.c = co;
        res.val.v = sv[MSB] ^ co;
        case (op)
            OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR: begin
                res.y   = sv;
                res.wen = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};
            end
            default: begin
                res.y   = a;
                res.wen = '0;
            end
        endcase
    end

    // R9: arithmetic right shift never changes the sign bit
    always_comb begin
        if (op == OP_ASR) begin
            assert_asr_sign_R9: assert (res.y[MSB] == a[MSB])
                else $error("arithmetic shift altered sign");
        end
    end

endmodule

// File: rtl/alu8_daa.sv
module alu8_daa
    import alu8_pkg::*;
(
    input  alu_op_e   op,
    input  word_t     a,
    input  logic      cin,
    input  logic      hin,
    output unit_res_t res
);

    logic [NIB_W-1:0] lo;
    logic [NIB_W-1:0] hi;
    logic             lo_big;
    logic             fix_lo;
    logic             fix_hi;
    word_t            corr;
    word_t            adj;

    always_comb begin
        lo     = a[NIB_W-1:0];
        hi     = a[DATA_W-1:NIB_W];
        lo_big = (lo > NIB_W'(BCD_MAX));
        fix_lo = hin || lo_big;
        fix_hi = cin || (hi > NIB_W'(BCD_MAX)) || ((hi == NIB_W'(BCD_MAX)) && lo_big);
        corr   = {(fix_hi ? NIB_W'(6) : NIB_W'(0)), (fix_lo ? NIB_W'(6) : NIB_W'(0))};
        adj    = a + corr;
    end

    always_comb begin
        res.val   = f_nz(adj);
        res.val.c = cin | fix_hi;
        if (op == OP_DAA) begin
            res.y   = adj;
            res.wen = '{h: 1'b0, n: 1'b1, z: 1'b1, v: 1'b0, c: 1'b1};
        end else begin
            res.y   = a;
            res.wen = '0;
        end
    end

    // R11: an incoming carry always survives the adjust
    always_comb begin
        if (op == OP_DAA && cin) begin
            assert_daa_carry_kept_R11: assert (res.val.c)
                else $error("decimal adjust lost carry");
        end
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              carry_in,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [CC_W-1:0]   cc_in,
    output logic [DATA_W-1:0] result,
    output logic [CC_W-1:0]   cc_out
);

    alu_op_e   op;
    unit_res_t r_ar;
    unit_res_t r_lg;
    unit_res_t r_sh;
    unit_res_t r_da;
    unit_res_t r_sel;

    logic [FLAG_CNT-1:0] cur_f;
    logic [FLAG_CNT-1:0] sel_val;
    logic [FLAG_CNT-1:0] sel_wen;
    logic [FLAG_CNT-1:0] nxt_f;
    flags_t              nxt;

    assign op = alu_op_e'(op_sel);

    alu8_arith u_arith (.op(op), .a(opa), .b(opb), .cin(carry_in), .res(r_ar));
    alu8_logic u_logic (.op(op), .a(opa), .b(opb), .res(r_lg));
    alu8_shift u_shift (.op(op), .a(opa), .cin(carry_in), .res(r_sh));
    alu8_daa   u_daa   (.op(op), .a(opa), .cin(carry_in), .hin(cc_in[5]), .res(r_da));

    always_comb begin
        case (f_unit(op))
            U_ARITH:  r_sel = r_ar;
            U_LOGIC:  r_sel = r_lg;
            U_SHIFT:  r_sel = r_sh;
            U_DECADJ: r_sel = r_da;
            default:  r_sel = '{y: opa, val: '0, wen: '0};
        endcase
    end

    // Present flags in flags_t order: h n z v c
    assign cur_f   = {cc_in[5], cc_in[3], cc_in[2], cc_in[1], cc_in[0]};
    assign sel_val = r_sel.val;
    assign sel_wen = r_sel.wen;

    generate
        for (genvar k = 0; k < FLAG_CNT; k++) begin : g_merge
            assign nxt_f[k] = sel_wen[k] ? sel_val[k] : cur_f[k];
        end
    endgenerate

    assign nxt    = flags_t'(nxt_f);
    assign result = r_sel.y;
    assign cc_out = {2'b11, nxt.h, cc_in[4], nxt.n, nxt.z, nxt.v, nxt.c};

    always_comb begin
        if (op_sel != OP_ADD && op_sel != OP_ADC) begin
            assert_h_kept_R12: assert (cc_out[5] == cc_in[5])
                else $error("half carry changed by non-add op");
        end
        if (op_sel == OP_INC || op_sel == OP_DEC) begin
            assert_carry_kept_R7: assert (cc_out[0] == cc_in[0])
                else $error("inc/dec changed carry");
        end
        if (op_sel == OP_CLR) begin
            assert_clear_flags_R8: assert (result == '0 && cc_out[3:0] == 4'b0100)
                else $error("clear produced wrong value");
        end
        if (op_sel <= OP_PASS && op_sel != OP_CMP && op_sel != OP_BIT && op_sel != OP_TST) begin
            assert_z_tracks_result_R1: assert (cc_out[2] == (result == '0))
                else $error("zero flag disagrees with result");
        end
        if (op_sel > OP_PASS) begin
            assert_unused_passes_R13: assert (result == opa && cc_out == (cc_in | 8'hC0))
                else $error("unused code altered state");
        end
    end

endmodule

// File: tb/alu8_core_test.sv
module alu8_core_test;

    logic       clk = 1'b0;
    logic [7:0] opa;
    logic [7:0] opb;
    logic       carry_in;
    logic [4:0] op_sel;
    logic [7:0] cc_in;
    logic [7:0] result;
    logic [7:0] cc_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    alu8_core uut (
        .opa(opa), .opb(opb), .carry_in(carry_in), .op_sel(op_sel),
        .cc_in(cc_in), .result(result), .cc_out(cc_out)
    );

    function automatic string req_of(int op);
        case (op)
            0, 1:              return "R2";
            2, 3, 4:           return "R3";
            5, 6, 7, 8, 21:    return "R4";
            9:                 return "R5";
            10:                return "R6";
            11, 12:            return "R7";
            13, 14:            return "R8";
            15, 16, 17:        return "R9";
            18, 19:            return "R10";
            20:                return "R11";
            default:           return "R13";
        endcase
    endfunction

    // Returns {result, cc_out} from the requirement text
    function automatic logic [15:0] model(int op, int a, int b, int ci, int cc);
        int y, r, s, d, cin, lo, hi, corr;
        int h, i, n, z, v, c;
        bit nz;
        h = (cc >> 5) & 1; i = (cc >> 4) & 1; n = (cc >> 3) & 1;
        z = (cc >> 2) & 1; v = (cc >> 1) & 1; c = cc & 1;
        y = a; r = a; nz = 1;
        case (op)
            0, 1: begin
                cin = (op == 1) ? ci : 0;
                s = a + b + cin; r = s % 256; y = r;
                h = ((a % 16) + (b % 16) + cin) > 15 ? 1 : 0;
                c = s > 255 ? 1 : 0;
                v = ((a >= 128) == (b >= 128)) && ((r >= 128) != (a >= 128)) ? 1 : 0;
            end
            2, 3, 4: begin
                cin = (op == 3) ? ci : 0;
                d = a - b - cin; r = (d + 512) % 256;
                y = (op == 4) ? a : r;
                c = d < 0 ? 1 : 0;
                v = ((a >= 128) != (b >= 128)) && ((r >= 128) != (a >= 128)) ? 1 : 0;
            end
            5:  begin r = a & b; y = r; v = 0; end
            6:  begin r = a | b; y = r; v = 0; end
            7:  begin r = a ^ b; y = r; v = 0; end
            8:  begin r = a & b; y = a; v = 0; end
            21: begin r = b;     y = r; v = 0; end
            9:  begin r = 255 - a; y = r; v = 0; c = 1; end
            10: begin r = (256 - a) % 256; y = r; c = (a != 0); v = (a == 128); end
            11: begin r = (a + 1) % 256; y = r; v = (a == 127); end
            12: begin r = (a + 255) % 256; y = r; v = (a == 128); end
            13: begin r = 0; y = 0; v = 0; c = 0; end
            14: begin r = a; y = a; v = 0; c = 0; end
            15: begin r = (a * 2) % 256; y = r; c = a / 128; end
            16: begin r = a / 2 + (a & 128); y = r; c = a % 2; end
            17: begin r = a / 2; y = r; c = a % 2; end
            18: begin r = (a * 2) % 256 + ci; y = r; c = a / 128; end
            19: begin r = a / 2 + ci * 128; y = r; c = a % 2; end
            20: begin
                lo = a % 16; hi = a / 16; corr = 0;
                if (h == 1 || lo > 9) corr += 6;
                if (ci == 1 || hi > 9 || (hi == 9 && lo > 9)) corr += 96;
                r = (a + corr) % 256; y = r;
                c = (ci == 1 || corr >= 96) ? 1 : 0;
            end
            default: nz = 0;
        endcase
        if (nz) begin
            n = r >= 128 ? 1 : 0;
            z = r == 0 ? 1 : 0;
        end
        if (op >= 15 && op <= 19) v = n ^ c;
        return {8'(y), 2'b11, 1'(h), 1'(i), 1'(n), 1'(z), 1'(v), 1'(c)};
    endfunction

    task automatic note(bit ok, string tag, string what, int op, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s op=%0d a=%02h b=%02h cin=%0d cc=%02h actual=%02h expected=%02h",
                     tag, what, op, opa, opb, carry_in, cc_in, act, exp);
        end
    endtask

    task automatic run_vec(int op, int a, int b, int ci, logic [7:0] cc);
        logic [15:0] e;
        op_sel = 5'(op); opa = 8'(a); opb = 8'(b); carry_in = 1'(ci); cc_in = cc;
        #1;
        e = model(op, a, b, ci, int'(cc));
        note(result == e[15:8], req_of(op), "result", op, result, e[15:8]);
        note(cc_out == e[7:0],  req_of(op), "flags",  op, cc_out, e[7:0]);
        // R1: fixed bits and interrupt mask
        note(cc_out[7:6] == 2'b11 && cc_out[4] == cc[4], "R1", "fixed/I", op, cc_out, {2'b11, e[5], cc[4], e[3:0]});
        // R12: half carry kept outside add codes, V kept by decimal adjust
        if (op != 0 && op != 1)
            note(cc_out[5] == cc[5], "R12", "H kept", op, cc_out, {cc_out[7:6], cc[5], cc_out[4:0]});
        if (op == 20)
            note(cc_out[1] == cc[1], "R12", "V kept", op, cc_out, {cc_out[7:2], cc[1], cc_out[0]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        opa = '0; opb = '0; carry_in = 1'b0; op_sel = '0; cc_in = '0;
        #2;
        for (int op = 0; op < 32; op++) begin
            if (op <= 8 || op == 21) begin
                // binary codes: R2 R3 R4
                for (int a = 0; a < 256; a++)
                    for (int b = 0; b < 256; b += 5)
                        for (int ci = 0; ci < 2; ci++)
                            run_vec(op, a, b, ci, 8'((a * 37) ^ (b * 11) ^ (ci * 64)));
            end else begin
                // unary, shift, decimal adjust and unused codes: R5..R11, R13
                for (int a = 0; a < 256; a++)
                    for (int ci = 0; ci < 2; ci++)
                        for (int hb = 0; hb < 2; hb++) begin
                            logic [7:0] cc;
                            cc = 8'(a * 29 + ci * 3 + hb * 70);
                            cc[5] = 1'(hb);
                            run_vec(op, a, a ^ 8'h5A, ci, cc);
                        end
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule